// File: doc/BRIEF.md
# Speculative Privilege Mode Tracker

This block follows the supervisor/user privilege mode through an out-of-order pipeline, so that a mode change does not have to stall the machine. It keeps three kinds of copy of the mode:

- a speculative future copy at fetch, which drives address translation and tags each fetched micro-op;
- one snapshot per branch checkpoint;
- a committed copy at retire.

A branch mispredict reloads the future copy from the named checkpoint. An exception or full flush reloads it from the committed copy. A decode-side check flags any privileged opcode whose fetch tag says user mode.

Translation, checkpoint allocation policy and the reorder buffer sit outside the block. Each appears only as a simple valid/id/mode interface. The mode encoding is one bit: 1 is supervisor and 0 is user.

Top module: `priv_mode_tracker`

## Requirements
- R1: Reset sets all copies to supervisor (1). This covers `fut_mode`, `commit_mode` and every checkpoint slot.
- R2: A cycle with `fetch_valid` and `fetch_chg` high loads `fetch_new_mode` into `fut_mode` on the next cycle. When no update source is active, `fut_mode` holds its value. `fut_mode` is the tag given to the micro-op fetched in that cycle.
- R3: `irq_entry` sets `fut_mode` to supervisor on the next cycle. It wins over a fetched mode change in the same cycle.
- R4: `ckpt_alloc` writes into slot `ckpt_alloc_id` the `fut_mode` value present in that cycle, which is the value before any same-cycle update.
- R5: `restore_req` loads slot `restore_id` into `fut_mode` on the next cycle. It wins over `irq_entry` and fetched mode changes.
- R6: `flush_req` loads `fut_mode` with the committed mode on the next cycle. That committed mode includes a retire in the same cycle. A flush wins over a restore.
- R7: `commit_mode` changes only when `retire_valid` and `retire_chg` are both high. It then takes `retire_new_mode` on the next cycle.
- R8: `dec_viol` is high in the same cycle exactly when `dec_valid` and `dec_priv` are high and `dec_tag` is 0 (user).
- R9: A `ckpt_alloc` in a cycle that also has `restore_req` or `flush_req` is ignored, so the slot keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_valid | input | 1 | A micro-op is fetched this cycle |
| fetch_chg | input | 1 | The fetched micro-op changes the mode |
| fetch_new_mode | input | 1 | Mode set by the fetched micro-op |
| irq_entry | input | 1 | Interrupt entry fetched; switch to supervisor |
| ckpt_alloc | input | 1 | Allocate a branch checkpoint |
| ckpt_alloc_id | input | 3 | Slot being allocated |
| restore_req | input | 1 | Mispredict restore request |
| restore_id | input | 3 | Slot to restore from |
| flush_req | input | 1 | Exception or full flush |
| retire_valid | input | 1 | A micro-op retires |
| retire_chg | input | 1 | The retiring micro-op changes the mode |
| retire_new_mode | input | 1 | Mode committed by the retiring micro-op |
| dec_valid | input | 1 | Decode slot valid |
| dec_priv | input | 1 | Decoded opcode is privileged |
| dec_tag | input | 1 | Fetch-mode tag of the decoded micro-op |
| fut_mode | output | 1 | Future mode, used for translation and micro-op tagging |
| commit_mode | output | 1 | Committed architectural mode |
| dec_viol | output | 1 | Privilege violation flag for decode |

## Verification
Random traffic drives all update sources together, so the priority order among flush, restore, interrupt entry and fetched change is tried in every combination. A reference model tells a wrong winner apart from a correct one.

Directed cases cover the following situations:
- a checkpoint taken in the same cycle as a fetched change, which separates the old value from the new one as the snapshot;
- a restore racing an interrupt entry;
- an allocation colliding with a restore, which is only visible on a later restore of that slot;
- a flush with a same-cycle retire, which separates the stale committed value from the updated one.

Decode inputs are randomized independently, so that every tag/privilege combination reaches the violation flag.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef logic mode_t;
  localparam mode_t MODE_SUP = 1'b1;
  localparam mode_t MODE_USR = 1'b0;
endpackage

// File: rtl/pmt_rst_sync.sv
module pmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmt_commit_mode.sv
module pmt_commit_mode
  import pmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  retire_valid,
  input  logic  retire_chg,
  input  mode_t retire_new_mode,
  output mode_t commit_q,
  output mode_t commit_nxt
);
  logic commit_en;

  always_comb begin
    commit_en  = retire_valid & retire_chg;
    commit_nxt = commit_en ? retire_new_mode : commit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         commit_q <= MODE_SUP;
    else if (commit_en) commit_q <= commit_nxt;
  end
endmodule

// File: rtl/pmt_ckpt_file.sv
module pmt_ckpt_file
  import pmt_pkg::*;
#(
  parameter int NUM_CKPT = 8,
  localparam int ID_W = $clog2(NUM_CKPT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [ID_W-1:0] alloc_id,
  input  logic            block_wr,
  input  mode_t           snap_mode,
  input  logic [ID_W-1:0] rd_id,
  output mode_t           rd_mode
);
  mode_t slot_q [NUM_CKPT];

  for (genvar g = 0; g < NUM_CKPT; g++) begin : g_slot
    logic wr_en;
    always_comb wr_en = alloc & ~block_wr & (alloc_id == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[g] <= MODE_SUP;
      else if (wr_en) slot_q[g] <= snap_mode;
    end
  end

  always_comb rd_mode = slot_q[rd_id];
endmodule

// File: rtl/pmt_future_mode.sv
module pmt_future_mode
  import pmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush_req,
  input  mode_t flush_mode,
  input  logic  restore_req,
  input  mode_t restore_mode,
  input  logic  irq_entry,
  input  logic  fetch_valid,
  input  logic  fetch_chg,
  input  mode_t fetch_new_mode,
  output mode_t fut_q
);
  mode_t fut_nxt;
  logic  fut_en;

  always_comb begin
    fut_en  = 1'b1;
    fut_nxt = fut_q;
    if (flush_req)                     fut_nxt = flush_mode;
    else if (restore_req)              fut_nxt = restore_mode;
    else if (irq_entry)                fut_nxt = MODE_SUP;
    else if (fetch_valid && fetch_chg) fut_nxt = fetch_new_mode;
    else                               fut_en  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fut_q <= MODE_SUP;
    else if (fut_en) fut_q <= fut_nxt;
  end
endmodule

// File: rtl/priv_mode_tracker.sv
module priv_mode_tracker
  import pmt_pkg::*;
#(
  parameter int NUM_CKPT = 8,
  localparam int ID_W = $clog2(NUM_CKPT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic            fetch_chg,
  input  logic            fetch_new_mode,
  input  logic            irq_entry,
  input  logic            ckpt_alloc,
  input  logic [ID_W-1:0] ckpt_alloc_id,
  input  logic            restore_req,
  input  logic [ID_W-1:0] restore_id,
  input  logic            flush_req,
  input  logic            retire_valid,
  input  logic            retire_chg,
  input  logic            retire_new_mode,
  input  logic            dec_valid,
  input  logic            dec_priv,
  input  logic            dec_tag,
  output logic            fut_mode,
  output logic            commit_mode,
  output logic            dec_viol
);
  logic  rst_sync_n;
  mode_t commit_nxt;
  mode_t ckpt_rd_mode;
  logic  redirect;

  pmt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pmt_commit_mode u_commit (
    .clk(clk), .rst_n(rst_sync_n),
    .retire_valid(retire_valid), .retire_chg(retire_chg),
    .retire_new_mode(retire_new_mode),
    .commit_q(commit_mode), .commit_nxt(commit_nxt)
  );

  always_comb redirect = restore_req | flush_req;

  pmt_ckpt_file #(.NUM_CKPT(NUM_CKPT)) u_ckpt (
    .clk(clk), .rst_n(rst_sync_n),
    .alloc(ckpt_alloc), .alloc_id(ckpt_alloc_id),
    .block_wr(redirect), .snap_mode(fut_mode),
    .rd_id(restore_id), .rd_mode(ckpt_rd_mode)
  );

  pmt_future_mode u_fut (
    .clk(clk), .rst_n(rst_sync_n),
    .flush_req(flush_req), .flush_mode(commit_nxt),
    .restore_req(restore_req), .restore_mode(ckpt_rd_mode),
    .irq_entry(irq_entry),
    .fetch_valid(fetch_valid), .fetch_chg(fetch_chg),
    .fetch_new_mode(fetch_new_mode),
    .fut_q(fut_mode)
  );

  always_comb dec_viol = dec_valid & dec_priv & (dec_tag == MODE_USR);
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker (
  input logic clk,
  input logic rst_sync_n,
  input logic fetch_valid,
  input logic fetch_chg,
  input logic irq_entry,
  input logic restore_req,
  input logic flush_req,
  input logic retire_valid,
  input logic retire_chg,
  input logic dec_valid,
  input logic dec_priv,
  input logic dec_tag,
  input logic ckpt_rd_mode,
  input logic fut_mode,
  input logic commit_mode,
  input logic dec_viol
);
  // R2
  fut_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(flush_req || restore_req || irq_entry || (fetch_valid && fetch_chg))
      |=> $stable(fut_mode));
  // R3
  irq_sup_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_entry && !restore_req && !flush_req) |=> fut_mode);
  // R5
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (restore_req && !flush_req) |=> (fut_mode == $past(ckpt_rd_mode)));
  // R6
  flush_commit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_req |=> (fut_mode == commit_mode));
  // R7
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(retire_valid && retire_chg) |=> $stable(commit_mode));
  // R8
  viol_sup_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_tag || !dec_valid || !dec_priv) |-> !dec_viol);
endmodule

bind priv_mode_tracker pmt_checker u_pmt_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .fetch_valid(fetch_valid), .fetch_chg(fetch_chg), .irq_entry(irq_entry),
  .restore_req(restore_req), .flush_req(flush_req),
  .retire_valid(retire_valid), .retire_chg(retire_chg),
  .dec_valid(dec_valid), .dec_priv(dec_priv), .dec_tag(dec_tag),
  .ckpt_rd_mode(ckpt_rd_mode), .fut_mode(fut_mode),
  .commit_mode(commit_mode), .dec_viol(dec_viol)
);

// File: tb/tb_priv_mode_tracker.sv
`timescale 1ns/1ps
module tb_priv_mode_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid, fetch_chg, fetch_new_mode, irq_entry;
  logic ckpt_alloc, restore_req, flush_req;
  logic [2:0] ckpt_alloc_id, restore_id;
  logic retire_valid, retire_chg, retire_new_mode;
  logic dec_valid, dec_priv, dec_tag;
  logic fut_mode, commit_mode, dec_viol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic fut_m, com_m;
  logic ck_m [8];

  always #4 clk = ~clk;

  priv_mode_tracker dut (.*);

  function automatic logic exp_commit(logic c);
    return (retire_valid && retire_chg) ? retire_new_mode : c;
  endfunction

  function automatic logic exp_fut(logic f, logic c);
    if (flush_req)                     return exp_commit(c);
    if (restore_req)                   return ck_m[restore_id];
    if (irq_entry)                     return 1'b1;
    if (fetch_valid && fetch_chg)      return fetch_new_mode;
    return f;
  endfunction

  function automatic logic exp_viol();
    return dec_valid && dec_priv && !dec_tag;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fut_m <= 1'b1;
      com_m <= 1'b1;
      for (int i = 0; i < 8; i++) ck_m[i] <= 1'b1;
    end else begin
      fut_m <= exp_fut(fut_m, com_m);
      com_m <= exp_commit(com_m);
      if (ckpt_alloc && !restore_req && !flush_req) ck_m[ckpt_alloc_id] <= fut_m;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R5 R6 fut_mode", fut_mode, fut_m);
    chk("R7 commit_mode", commit_mode, com_m);
    chk("R8 dec_viol", dec_viol, exp_viol());
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_chg = 0; fetch_new_mode = 0; irq_entry = 0;
    ckpt_alloc = 0; ckpt_alloc_id = 0; restore_req = 0; restore_id = 0;
    flush_req = 0; retire_valid = 0; retire_chg = 0; retire_new_mode = 0;
    dec_valid = 0; dec_priv = 0; dec_tag = 0;
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fut reset", fut_mode, 1'b1);
    chk("R1 commit reset", commit_mode, 1'b1);
    restore_req = 1; restore_id = 3'd5;
    step(); idle();
    chk("R1 checkpoint reset", fut_mode, 1'b1);
    // R2 fetch to user
    fetch_valid = 1; fetch_chg = 1; fetch_new_mode = 0;
    step(); idle();
    chk("R2 fetch change", fut_mode, 1'b0);
    // R4 snapshot with same-cycle fetch change back to supervisor
    ckpt_alloc = 1; ckpt_alloc_id = 3'd2;
    fetch_valid = 1; fetch_chg = 1; fetch_new_mode = 1;
    step(); idle();
    chk("R2 fetch to sup", fut_mode, 1'b1);
    // R3 irq over fetch change to user
    fetch_valid = 1; fetch_chg = 1; fetch_new_mode = 0; irq_entry = 1;
    step(); idle();
    chk("R3 irq priority", fut_mode, 1'b1);
    // R5 restore slot 2 beats irq
    restore_req = 1; restore_id = 3'd2; irq_entry = 1;
    step(); idle();
    chk("R4 R5 restore snapshot", fut_mode, 1'b0);
    // R9 alloc slot 3 colliding with restore (fut=0 would be written)
    ckpt_alloc = 1; ckpt_alloc_id = 3'd3; restore_req = 1; restore_id = 3'd2;
    step(); idle();
    restore_req = 1; restore_id = 3'd3;
    step(); idle();
    chk("R9 alloc ignored", fut_mode, 1'b1);
    // R6 R7 flush with same-cycle retire to user, restore also requested
    flush_req = 1; retire_valid = 1; retire_chg = 1; retire_new_mode = 0;
    restore_req = 1; restore_id = 3'd3;
    step(); idle();
    chk("R6 flush uses new commit", fut_mode, 1'b0);
    chk("R7 commit updated", commit_mode, 1'b0);
    // R7 retire without change flag
    retire_valid = 1; retire_new_mode = 1;
    step(); idle();
    chk("R7 commit held", commit_mode, 1'b0);
    // R8 privileged op tagged user
    dec_valid = 1; dec_priv = 1; dec_tag = 0;
    #1 chk("R8 violation", dec_viol, 1'b1);
    dec_tag = 1;
    #1 chk("R8 no violation", dec_viol, 1'b0);
    step(); idle();
    // random phase
    for (int k = 0; k < 3000; k++) begin
      fetch_valid     = $urandom_range(0, 1);
      fetch_chg       = ($urandom_range(0, 2) == 0);
      fetch_new_mode  = $urandom_range(0, 1);
      irq_entry       = ($urandom_range(0, 9) == 0);
      ckpt_alloc      = ($urandom_range(0, 2) == 0);
      ckpt_alloc_id   = 3'($urandom_range(0, 7));
      restore_req     = ($urandom_range(0, 7) == 0);
      restore_id      = 3'($urandom_range(0, 7));
      flush_req       = ($urandom_range(0, 15) == 0);
      retire_valid    = $urandom_range(0, 1);
      retire_chg      = ($urandom_range(0, 2) == 0);
      retire_new_mode = $urandom_range(0, 1);
      dec_valid       = $urandom_range(0, 1);
      dec_priv        = $urandom_range(0, 1);
      dec_tag         = $urandom_range(0, 1);
      step();
    end
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule